// File: doc/BRIEF.md
# Prioritized Multifunction Shift Register

A synchronous register of parameterizable width with five independent active-high control lines: clear, set, parallel load, shift toward the LSB and shift toward the MSB. A fixed priority resolver turns these lines into one encoded select per clock. That select drives a multiplexer in front of each flip-flop. When no line is asserted, the register keeps its value. Each shift direction has its own serial input. The parallel output always shows the register contents.

The block is meant for datapaths that must capture, zero, fill or shift a word under control from an FSM. Several control lines may be asserted in the same cycle; the priority makes the outcome of any combination fully defined. All changes happen on the rising clock edge. An asynchronous active-low reset sets the register to zero at power-up.

Top module: `prio_shift_reg`

## Requirements
- R1: While `rst_n` is low, `q_o` is all zeros.
- R2: With no control line asserted at a rising edge, `q_o` keeps its previous value.
- R3: When `clr_i` is high at an edge, the next `q_o` is all zeros, whatever the other control lines are (including `set_i`).
- R4: When `set_i` is high and `clr_i` is low, the next `q_o` is all ones.
- R5: When `load_i` is high and neither clear nor set is high, the next `q_o` equals `d_i`, and both shift lines are ignored.
- R6: When `shr_i` is high and clear, set and load are low, `q_o` moves one bit toward the LSB. Bit W-1 takes `shr_in_i`. Starting from 1001 with a serial input of 0, four shifts give 0100, 0010, 0001 and 0000.
- R7: When `shl_i` is the only asserted line among the five, `q_o` moves one bit toward the MSB and bit 0 takes `shl_in_i`.
- R8: The priority, from highest to lowest, is clear, set, load, shift right, shift left. Every one of the 32 control combinations yields the result of the highest asserted line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear to zeros |
| set_i | input | 1 | Synchronous set to ones |
| load_i | input | 1 | Parallel load of d_i |
| shr_i | input | 1 | Shift toward LSB |
| shl_i | input | 1 | Shift toward MSB |
| shr_in_i | input | 1 | Serial bit entering the MSB on a right shift |
| shl_in_i | input | 1 | Serial bit entering the LSB on a left shift |
| d_i | input | W | Parallel data |
| q_o | output | W | Register contents |

## Verification
The block has exactly one register stage. Every control and data input sampled at a rising edge therefore shows up on `q_o` right after that same edge. The bench drives its inputs on the falling edge. After each rising edge it advances a behavioural model, and it compares `q_o` with the model at the next falling edge, half a period after the update. A hold cycle is checked the same way: the expected value is the previous state, so any unwanted change shows up at once.

// File: rtl/prio_shift_reg_pkg.sv
package prio_shift_reg_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD  = 3'd0,
    SEL_LOAD  = 3'd1,
    SEL_SHR   = 3'd2,
    SEL_SHL   = 3'd3,
    SEL_CLR   = 3'd4,
    SEL_SET   = 3'd5
  } op_sel_e;
endpackage

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_shift_reg_pkg::*;
(
  input  logic    clr_i,
  input  logic    set_i,
  input  logic    load_i,
  input  logic    shr_i,
  input  logic    shl_i,
  output op_sel_e sel_o
);
  always_comb begin
    if (clr_i)       sel_o = SEL_CLR;
    else if (set_i)  sel_o = SEL_SET;
    else if (load_i) sel_o = SEL_LOAD;
    else if (shr_i)  sel_o = SEL_SHR;
    else if (shl_i)  sel_o = SEL_SHL;
    else             sel_o = SEL_HOLD;
  end

  // R8: an asserted clear always wins the resolution
  always_comb begin
    if (clr_i) a_r8_clr_wins: assert (sel_o == SEL_CLR);
  end
endmodule

// File: rtl/bit_mux8.sv
module bit_mux8
  import prio_shift_reg_pkg::*;
(
  input  op_sel_e sel_i,
  input  logic    cur_i,
  input  logic    par_i,
  input  logic    left_nb_i,
  input  logic    right_nb_i,
  output logic    nxt_o
);
  always_comb begin
    unique case (sel_i)
      SEL_LOAD: nxt_o = par_i;
      SEL_SHR:  nxt_o = left_nb_i;
      SEL_SHL:  nxt_o = right_nb_i;
      SEL_CLR:  nxt_o = 1'b0;
      SEL_SET:  nxt_o = 1'b1;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import prio_shift_reg_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         set_i,
  input  logic         load_i,
  input  logic         shr_i,
  input  logic         shl_i,
  input  logic         shr_in_i,
  input  logic         shl_in_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int MSB = W - 1;

  op_sel_e      sel;
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic [W+1:0] ext;

  prio_resolver u_res (
    .clr_i (clr_i),
    .set_i (set_i),
    .load_i(load_i),
    .shr_i (shr_i),
    .shl_i (shl_i),
    .sel_o (sel)
  );

  assign ext = {shr_in_i, q_q, shl_in_i};

  for (genvar i = 0; i < W; i++) begin : g_bit
    bit_mux8 u_mux (
      .sel_i     (sel),
      .cur_i     (q_q[i]),
      .par_i     (d_i[i]),
      .left_nb_i (ext[i+2]),
      .right_nb_i(ext[i]),
      .nxt_o     (q_d[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_i || set_i || load_i || shr_i || shl_i) |=> $stable(q_o));
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q_o == '0));
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> (q_o == '1));
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i && !set_i) |=> (q_o == $past(d_i)));
  a_r6_shr: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_i && !load_i && !clr_i && !set_i) |=>
      (q_o == {$past(shr_in_i), $past(q_o[MSB:1])}));
  a_r7_shl: assert property (@(posedge clk) disable iff (!rst_n)
    (shl_i && !shr_i && !load_i && !clr_i && !set_i) |=>
      (q_o == {$past(q_o[MSB-1:0]), $past(shl_in_i)}));
endmodule

// File: tb/prio_shift_reg_bench.sv
module prio_shift_reg_bench;
  localparam int W = 4;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic clr, set, ld, shr, shl, sin_r, sin_l;
  logic [W-1:0] d, q;
  logic [W-1:0] model;
  int total = 0, bad = 0;
  int cyc = 0;

  always #(TCLK/2) clk = ~clk;

  prio_shift_reg #(.W(W)) u_prio_shift_reg (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .set_i(set), .load_i(ld),
    .shr_i(shr), .shl_i(shl), .shr_in_i(sin_r), .shl_in_i(sin_l),
    .d_i(d), .q_o(q));

  function automatic string tag_of();
    if (clr) return "R3";
    if (set) return "R4";
    if (ld)  return "R5";
    if (shr) return "R6";
    if (shl) return "R7";
    return "R2";
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    total++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic step(logic [4:0] c, logic [W-1:0] dv, logic sr, logic sl,
                      string req = "");
    string t;
    {clr, set, ld, shr, shl} = c;
    d = dv; sin_r = sr; sin_l = sl;
    t = (req == "") ? tag_of() : req;
    if (clr)      model = '0;
    else if (set) model = '1;
    else if (ld)  model = dv;
    else if (shr) model = {sr, model[W-1:1]};
    else if (shl) model = {model[W-2:0], sl};
    @(posedge clk);
    @(negedge clk);
    check(t, model);
  endtask

  initial begin
    #(TCLK*5000);
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    {clr, set, ld, shr, shl, sin_r, sin_l} = '0;
    d = 4'b1111;
    model = '0;
    @(negedge clk); @(negedge clk);
    check("R1", 4'b0000);
    rst_n = 1;
    @(negedge clk);
    // R5 load then R6 sequence 1001 -> 0100 0010 0001 0000
    step(5'b00100, 4'b1001, 0, 0, "R5");
    for (int k = 0; k < 4; k++) step(5'b00010, 4'b0110, 0, 1, "R6");
    // R6 serial 1 in
    step(5'b00010, 4'b0000, 1, 0, "R6");
    step(5'b00010, 4'b0000, 1, 0, "R6");
    // R7 left shifts
    step(5'b00001, 4'b0000, 0, 1, "R7");
    step(5'b00001, 4'b0000, 1, 0, "R7");
    // R2 hold
    step(5'b00000, 4'b1010, 1, 1, "R2");
    step(5'b00000, 4'b0101, 0, 0, "R2");
    // R4 set, R3 clear with set
    step(5'b01000, 4'b0000, 0, 0, "R4");
    step(5'b11000, 4'b1111, 1, 1, "R3");
    // R8 all 32 combinations, from varied states
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 32; c++) begin
        step(5'b00100, 4'(c * 5 + r * 3), 0, 0, "R8");
        step(5'(c), 4'(c ^ 4'hA + r), r[0], ~r[0], "R8");
      end
    // R1 reset mid-run
    step(5'b01000, 4'b0000, 0, 0, "R4");
    @(negedge clk); rst_n = 0; #1;
    check("R1", 4'b0000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule